// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block connects an 8-bit host processor to the register files of two serial channels. A static mode pin picks how the host pins are read. In one mode the host uses separate active-low read and write strobes and one chip select per channel. In the other mode the host uses one chip select and one direction line, and the second channel's select pin becomes a fourth address bit. The block decodes the channel and a 3-bit register index. It issues single-cycle read and write pulses to the register files, and it drives the bidirectional data bus during reads.

All host pins are asynchronous to the internal clock, so they pass through a synchronizer chain before decoding. A read pulse is issued when an access starts. A write pulse is issued once, when the access ends, and it carries the address and data seen in the last active cycle. The byte returned by the register file is held in a register and placed on the bus for as long as the read continues.

Top module: `host_bus_bridge`

## Requirements
- R1: `busModeIntel` high selects strobe mode and low selects direction mode. In both modes the same register file is reached: a byte written in one mode reads back in the other.
- R2: In strobe mode, with exactly one chip select low, a synchronized falling edge of `hostRdN` gives one `regRdPulse`, SYNC_STAGES+1 clock edges after the pin change. `regIdx` equals `hostAddr`, and `regChan` is 0 for `hostSelAN` or 1 for `hostSelBN`.
- R3: In strobe mode, `hostWrN` low with exactly one chip select low is a write access. When it ends, `regWrPulse` is high for one cycle, with `regIdx`, `regChan` and `regWrData` taken from the last cycle in which the access was active.
- R4: In direction mode, an access is active while `hostSelAN` is low. `hostWrN` high makes it a read, with the read pulse at its start. `hostWrN` low makes it a write, with the write pulse after `hostSelAN` returns high.
- R5: In direction mode, `hostSelBN` acts as address bit 3: 0 selects channel 0 and 1 selects channel 1 on `regChan`.
- R6: `hostData` is driven with the byte that `regRdData` presented during the read pulse. Driving starts one cycle after the pulse and lasts while the synchronized read stays active. At all other times the bus is released.
- R7: In strobe mode, both chip selects low together produce no read pulse, no write pulse and no bus drive.
- R8: In direction mode, `hostRdN` has no effect.
- R9: After reset, both pulses are low, `regChan`, `regIdx` and `regWrData` are 0, and the bus is released.
- R10: One write access yields exactly one write pulse, however long the strobe is held. Every pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busModeIntel | input | 1 | Static mode: 1 strobe mode, 0 direction mode |
| hostAddr | input | 3 | Register index from the host |
| hostData | inout | 8 | Bidirectional host data bus |
| hostRdN | input | 1 | Read strobe, active low (unused in direction mode) |
| hostWrN | input | 1 | Write strobe, active low; in direction mode 1 = read, 0 = write |
| hostSelAN | input | 1 | Channel 0 select, active low; the only chip select in direction mode |
| hostSelBN | input | 1 | Channel 1 select, active low; address bit 3 in direction mode |
| regRdData | input | 8 | Byte returned by the register file at `regChan`/`regIdx` |
| regRdPulse | output | 1 | One-cycle read request |
| regWrPulse | output | 1 | One-cycle write commit |
| regChan | output | 1 | Addressed channel |
| regIdx | output | 3 | Addressed register index |
| regWrData | output | 8 | Byte to be written |

## Verification
The bench builds the block with its defaults: a 3-bit index, an 8-bit bus and a two-stage synchronizer. With these values the pulse latency is three edges, so the bench model can place every pulse and every bus-drive cycle exactly. It also keeps all eight registers of both channels in its own register-file model. This covers writes and read-backs in both modes, both chip selects active at once, a read strobe that toggles while in direction mode, and a strobe held for many cycles.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef struct packed {
    logic rdPulse;
    logic wrPulse;
    logic capture;
    logic driveOn;
    logic chan;
  } hbusStrobes_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[g] <= RESET_VAL;
        else       stageQ[g] <= din;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stageQ[g] <= RESET_VAL;
        else       stageQ[g] <= stageQ[g-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busModeIntel,
  input  logic         hostRdN,
  input  logic         hostWrN,
  input  logic         hostSelAN,
  input  logic         hostSelBN,
  output hbusStrobes_t strobes
);
  logic [3:0] pinSync;
  logic rdS, wrS, selAS, selBS;
  logic selOk, chanNow, rdAct, wrAct;
  logic rdActQ, wrActQ, rdPulseQ, wrPulseQ, driveQ;

  // control pins idle high, so reset the chain to all ones
  hbus_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'hF)) u_pinSync (
    .clk (clk),
    .rstN(rstN),
    .din ({hostRdN, hostWrN, hostSelAN, hostSelBN}),
    .dout(pinSync)
  );
  assign {rdS, wrS, selAS, selBS} = pinSync;

  always_comb begin
    if (busModeIntel) begin
      selOk   = selAS ^ selBS;          // exactly one select low
      chanNow = selAS;                  // A low -> 0, B low -> 1
      rdAct   = selOk & ~rdS;
      wrAct   = selOk & ~wrS & rdS;
    end else begin
      selOk   = ~selAS;
      chanNow = selBS;                  // fourth address bit
      rdAct   = selOk & wrS;
      wrAct   = selOk & ~wrS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActQ   <= 1'b0;
      wrActQ   <= 1'b0;
      rdPulseQ <= 1'b0;
      wrPulseQ <= 1'b0;
      driveQ   <= 1'b0;
    end else begin
      rdActQ   <= rdAct;
      wrActQ   <= wrAct;
      rdPulseQ <= rdAct & ~rdActQ;
      wrPulseQ <= ~wrAct & wrActQ;
      driveQ   <= rdAct & rdActQ;
    end
  end

  assign strobes.rdPulse = rdPulseQ;
  assign strobes.wrPulse = wrPulseQ;
  assign strobes.capture = rdAct | wrAct;
  assign strobes.driveOn = driveQ;
  assign strobes.chan    = chanNow;
endmodule

// File: rtl/hbus_datapath.sv
module hbus_datapath
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbusStrobes_t      strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regChan,
  output logic [ADDR_W-1:0] regIdx,
  output logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [BUS_W-1:0]  busSync;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  logic [DATA_W-1:0] rdLatch;

  hbus_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_busSync (
    .clk (clk),
    .rstN(rstN),
    .din ({hostAddr, hostDataIn}),
    .dout(busSync)
  );
  assign {addrS, dataS} = busSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regChan   <= 1'b0;
      regIdx    <= '0;
      regWrData <= '0;
      rdLatch   <= '0;
    end else begin
      if (strobes.capture) begin
        regChan   <= strobes.chan;
        regIdx    <= addrS;
        regWrData <= dataS;
      end
      if (strobes.rdPulse) rdLatch <= regRdData;
    end
  end

  assign busOut = rdLatch;
  assign busOe  = strobes.driveOn;
endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busModeIntel,
  input  logic [ADDR_W-1:0] hostAddr,
  inout  wire  [DATA_W-1:0] hostData,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostSelAN,
  input  logic              hostSelBN,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regRdPulse,
  output logic              regWrPulse,
  output logic              regChan,
  output logic [ADDR_W-1:0] regIdx,
  output logic [DATA_W-1:0] regWrData
);
  hbusStrobes_t      strobes;
  logic [DATA_W-1:0] busOut;
  logic              busOe;

  hbus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busModeIntel(busModeIntel),
    .hostRdN     (hostRdN),
    .hostWrN     (hostWrN),
    .hostSelAN   (hostSelAN),
    .hostSelBN   (hostSelBN),
    .strobes     (strobes)
  );

  hbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostAddr  (hostAddr),
    .hostDataIn(hostData),
    .regRdData (regRdData),
    .regChan   (regChan),
    .regIdx    (regIdx),
    .regWrData (regWrData),
    .busOut    (busOut),
    .busOe     (busOe)
  );

  assign hostData   = busOe ? busOut : 'z;
  assign regRdPulse = strobes.rdPulse;
  assign regWrPulse = strobes.wrPulse;
endmodule

// File: rtl/hbus_checks.sv
// Delays below assume the default two-stage synchronizer.
module hbus_checks (
  input logic clk,
  input logic rstN,
  input logic busModeIntel,
  input logic hostRdN,
  input logic hostWrN,
  input logic hostSelAN,
  input logic hostSelBN,
  input logic regRdPulse,
  input logic regWrPulse
);
  logic bothSel;
  assign bothSel = busModeIntel & ~hostSelAN & ~hostSelBN;

  p_rd_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    regRdPulse |=> !regRdPulse);

  p_wr_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWrPulse |=> !regWrPulse);

  p_both_sel_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(bothSel, 3) && $past(bothSel, 4)) |-> (!regRdPulse && !regWrPulse));

  p_rd_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdPulse && busModeIntel) |-> ($past(!hostRdN, 3) && $past(hostSelAN != hostSelBN, 3)));

  p_rd_origin_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdPulse && !busModeIntel) |-> ($past(!hostSelAN, 3) && $past(hostWrN, 3)));

  p_wr_origin_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrPulse && busModeIntel) |-> ($past(!hostWrN, 4) && $past(hostRdN, 4)));
endmodule

bind host_bus_bridge hbus_checks u_hbusChecks (
  .clk         (clk),
  .rstN        (rstN),
  .busModeIntel(busModeIntel),
  .hostRdN     (hostRdN),
  .hostWrN     (hostWrN),
  .hostSelAN   (hostSelAN),
  .hostSelBN   (hostSelBN),
  .regRdPulse  (regRdPulse),
  .regWrPulse  (regWrPulse)
);

// File: tb/tb_host_bus_bridge.sv
module tb_host_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busModeIntel = 1'b1;
  logic [2:0] hostAddr = '0;
  wire  [7:0] hostData;
  logic       hostRdN = 1'b1, hostWrN = 1'b1, hostSelAN = 1'b1, hostSelBN = 1'b1;
  logic [7:0] regRdData;
  logic       regRdPulse, regWrPulse, regChan;
  logic [2:0] regIdx;
  logic [7:0] regWrData;
  logic       tbDrv = 1'b0;
  logic [7:0] tbData = '0;

  assign hostData = tbDrv ? tbData : 8'bz;
  always #(CLK_PERIOD/2) clk = ~clk;

  host_bus_bridge #(.ADDR_W(3), .DATA_W(8), .SYNC_STAGES(S)) dut (
    .clk(clk), .rstN(rstN), .busModeIntel(busModeIntel), .hostAddr(hostAddr),
    .hostData(hostData), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostSelAN(hostSelAN), .hostSelBN(hostSelBN), .regRdData(regRdData),
    .regRdPulse(regRdPulse), .regWrPulse(regWrPulse), .regChan(regChan),
    .regIdx(regIdx), .regWrData(regWrData)
  );

  // register-file model attached to the block
  logic [7:0] rfMem [2][8];
  assign regRdData = rfMem[regChan][regIdx];
  always @(posedge clk) if (regWrPulse) rfMem[regChan][regIdx] <= regWrData;

  int vectors = 0, fails = 0;
  int rdCnt = 0, wrCnt = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference model: snapshot {mode,rdN,wrN,selA,selB,addr,data}
  logic [15:0] hist[$];
  logic [7:0]  mMem [2][8];
  logic mRd = 0, mWr = 0, mDrive = 0, mChan = 0;
  logic [2:0] mIdx = 0;
  logic [7:0] mWrData = 0, mLatch = 0;

  function automatic logic selOkF(logic [15:0] p);
    return p[15] ? (p[12] ^ p[11]) : ~p[12];
  endfunction
  function automatic logic rdActF(logic [15:0] p);
    return p[15] ? (selOkF(p) & ~p[14]) : (selOkF(p) & p[13]);
  endfunction
  function automatic logic wrActF(logic [15:0] p);
    return p[15] ? (selOkF(p) & ~p[13] & p[14]) : (selOkF(p) & ~p[13]);
  endfunction
  function automatic logic chanF(logic [15:0] p);
    return p[15] ? p[12] : p[11];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {};
      for (int i = 0; i < S + 2; i++) hist.push_front({busModeIntel, 4'hF, 3'd0, 8'd0});
      mRd = 0; mWr = 0; mDrive = 0; mChan = 0; mIdx = 0; mWrData = 0; mLatch = 0;
    end else begin
      logic [15:0] h, hp;
      logic [7:0] newLatch;
      hist.push_front({busModeIntel, hostRdN, hostWrN, hostSelAN, hostSelBN, hostAddr, hostData});
      if (hist.size() > 8) void'(hist.pop_back());
      h = hist[S]; hp = hist[S+1];
      newLatch = mRd ? mMem[mChan][mIdx] : mLatch;
      if (mWr) mMem[mChan][mIdx] = mWrData;
      mRd    = rdActF(h) & ~rdActF(hp);
      mWr    = ~wrActF(h) & wrActF(hp);
      mDrive = rdActF(h) & rdActF(hp);
      if (rdActF(h) | wrActF(h)) begin
        mChan = chanF(h); mIdx = h[10:8]; mWrData = h[7:0];
      end
      mLatch = newLatch;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (!done) begin
    check(regRdPulse == mRd, busModeIntel ? "R2" : "R4", "regRdPulse", regRdPulse, mRd);
    check(regWrPulse == mWr, busModeIntel ? "R3" : "R4", "regWrPulse", regWrPulse, mWr);
    check(regChan == mChan, "R5", "regChan", regChan, mChan);
    check(regIdx == mIdx, "R2", "regIdx", regIdx, mIdx);
    check(regWrData == mWrData, "R3", "regWrData", regWrData, mWrData);
    if (mDrive) check(hostData === mLatch, "R6", "hostData", hostData, mLatch);
    if (regRdPulse) rdCnt++;
    if (regWrPulse) wrCnt++;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic intelWrite(input logic ch, input logic [2:0] idx, input logic [7:0] d, input int hold);
    hostAddr = idx; tbData = d; tbDrv = 1;
    if (ch) hostSelBN = 0; else hostSelAN = 0;
    step(2); hostWrN = 0; step(hold); hostWrN = 1; step(2);
    hostSelAN = 1; hostSelBN = 1; tbDrv = 0; step(6);
  endtask

  task automatic intelRead(input logic ch, input logic [2:0] idx, output logic [7:0] d);
    hostAddr = idx;
    if (ch) hostSelBN = 0; else hostSelAN = 0;
    hostRdN = 0; step(7); d = hostData;
    hostRdN = 1; hostSelAN = 1; hostSelBN = 1; step(6);
  endtask

  task automatic motWrite(input logic ch, input logic [2:0] idx, input logic [7:0] d, input bit wiggleRd);
    hostSelBN = ch; hostAddr = idx; hostWrN = 0; tbData = d; tbDrv = 1; step(1);
    hostSelAN = 0; if (wiggleRd) hostRdN = 0; step(2); hostRdN = 1; step(2);
    hostSelAN = 1; step(1); tbDrv = 0; hostWrN = 1; hostSelBN = 1; step(6);
  endtask

  task automatic motRead(input logic ch, input logic [2:0] idx, output logic [7:0] d);
    hostSelBN = ch; hostAddr = idx; hostWrN = 1; step(1);
    hostSelAN = 0; step(7); d = hostData; hostSelAN = 1; step(1); hostSelBN = 1; step(6);
  endtask

  initial begin
    logic [7:0] got;
    int rdBase, wrBase;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 8; i++) begin
        rfMem[c][i] = 8'(c * 16 + i + 8'h20);
        mMem[c][i]  = 8'(c * 16 + i + 8'h20);
      end
    step(4);
    // R9: reset values
    check(!regRdPulse && !regWrPulse, "R9", "pulses", {regRdPulse, regWrPulse}, 0);
    check(regChan == 0 && regIdx == 0 && regWrData == 0, "R9", "chan/idx/data", {regChan, regIdx, regWrData}, 0);
    rstN = 1; step(3);

    // strobe mode writes and reads (R2, R3, R6)
    intelWrite(0, 3'd3, 8'h5A, 3);
    intelWrite(1, 3'd6, 8'hC3, 3);
    intelRead(0, 3'd3, got); check(got == 8'h5A, "R6", "read A3", got, 8'h5A);
    intelRead(1, 3'd6, got); check(got == 8'hC3, "R2", "read B6", got, 8'hC3);
    intelRead(1, 3'd0, got); check(got == 8'h30, "R2", "read B0", got, 8'h30);

    // R7: both selects low is ignored
    rdBase = rdCnt; wrBase = wrCnt;
    hostAddr = 3'd3; tbData = 8'hFF; tbDrv = 1; hostSelAN = 0; hostSelBN = 0;
    step(2); hostWrN = 0; step(4); hostWrN = 1; step(2); hostRdN = 0; step(5); hostRdN = 1;
    hostSelAN = 1; hostSelBN = 1; tbDrv = 0; step(6);
    check(rdCnt == rdBase && wrCnt == wrBase, "R7", "pulse count", rdCnt + wrCnt - rdBase - wrBase, 0);
    intelRead(0, 3'd3, got); check(got == 8'h5A, "R7", "A3 unchanged", got, 8'h5A);
    intelRead(1, 3'd3, got); check(got == 8'h33, "R7", "B3 unchanged", got, 8'h33);

    // R10: long strobe, single commit
    wrBase = wrCnt;
    intelWrite(0, 3'd7, 8'h77, 40);
    check(wrCnt == wrBase + 1, "R10", "write pulses", wrCnt - wrBase, 1);

    // direction mode (R1, R4, R5, R8)
    busModeIntel = 0; step(2);
    rdBase = rdCnt; wrBase = wrCnt;
    hostRdN = 0; step(3); hostRdN = 1; step(6);
    check(rdCnt == rdBase && wrCnt == wrBase, "R8", "idle read pin", rdCnt + wrCnt - rdBase - wrBase, 0);
    motWrite(0, 3'd1, 8'h11, 1);
    motWrite(1, 3'd7, 8'hE7, 1);
    check(wrCnt == wrBase + 2, "R8", "write count", wrCnt - wrBase, 2);
    motRead(0, 3'd1, got); check(got == 8'h11, "R4", "read A1", got, 8'h11);
    motRead(1, 3'd7, got); check(got == 8'hE7, "R5", "read B7", got, 8'hE7);
    motRead(1, 3'd6, got); check(got == 8'hC3, "R1", "cross-mode B6", got, 8'hC3);
    motRead(0, 3'd7, got); check(got == 8'h77, "R1", "cross-mode A7", got, 8'h77);

    busModeIntel = 1; step(2);
    intelRead(0, 3'd1, got); check(got == 8'h11, "R1", "back in strobe A1", got, 8'h11);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      fails++; vectors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule